// File: doc/BRIEF.md
# Pin-Triggered Converter Control Sequencer

This block is the digital control of a small sampling converter that has only three control and data pins: a conversion-start input, a serial clock input and a serial data output. The start pin alone moves the converter through its phases. A rising edge wakes the converter and begins tracking the input. A falling edge, once the acquisition window has elapsed, freezes the sample and starts a 12-step successive-approximation search. When the search ends, the block returns to shutdown by itself and presents the most significant result bit on the serial output.

The start pin also chooses the mode of each conversion. A single rising edge selects the default mode: channel 1 on the two-channel variant, unipolar on the differential variant. A short low pulse during acquisition, followed by a new rising edge, selects the alternate mode: channel 2, or bipolar. Starting a new conversion before the previous result has been fully read forces the alternate mode. In the differential variant, bipolar results are given in two's complement. The analog track/hold, the DAC and the power switches are outside the block. It drives them through the `track`, `hold`, `power_on`, `mode_alt` and `dac_code` outputs and reads back a single comparator bit. Both pins are synchronised into the system clock domain. The conversion clock is a divided tick of that clock.

Top module: `conv_seq_ctrl`

## Requirements
- R1: After reset the block is in shutdown: `power_on`, `track` and `hold` are 0, and `sdo_oe_n` is 1 (serial output released).
- R2: From shutdown, a rising start edge sets `power_on` and `track`. A falling start edge after at least ACQ_CYC tracking cycles clears `track` and sets `hold`. `track` and `hold` are never both 1.
- R3: A conversion uses DATA_W conversion ticks of TICK_DIV system cycles each. With the default parameters, `hold` stays high for 300 to 305 cycles, which is under 3.7 us.
- R4: When the conversion ends, the block returns to shutdown by itself (`power_on` = 0, `hold` = 0). The serial output is enabled and shows result bit 11.
- R5: While `power_on` is 1, `sdo` is 0 and `sdo_oe_n` is 0.
- R6: The result is shifted out MSB first. Each falling SCLK edge advances `sdo` from bit k to bit k-1, so bits 11 down to 0 appear in order.
- R7: After the 12th falling SCLK edge that follows a conversion, `sdo_oe_n` returns to 1.
- R8: SCLK edges are ignored while a conversion is running and in shutdown when no result bits are pending. A result read after SCLK toggled during the conversion is still correct, and `sdo_oe_n` stays 1.
- R9: A falling start edge before ACQ_CYC tracking cycles, followed by a new rising edge, selects the alternate mode (`mode_alt` = 1). A single rising edge selects the default mode (`mode_alt` = 0).
- R10: In the differential variant (VARIANT = 1) with `mode_alt` = 1, the result is two's complement, which is the search code with bit 11 inverted. In unipolar mode the result is straight binary, equal to the search code.
- R11: A rising start edge while result bits are still pending abandons the readout and forces `mode_alt` = 1 for the new conversion.
- R12: The search begins at `dac_code` = 0x800. On each tick the bit under trial is kept when `cmp_bit` is 1 and cleared when it is 0, and the next lower bit is then tried.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_pin | input | 1 | Conversion-start and mode-select pin (asynchronous) |
| sclk_pin | input | 1 | External serial clock (asynchronous) |
| cmp_bit | input | 1 | Comparator decision: 1 when the input is at or above `dac_code` |
| sdo | output | 1 | Serial result data |
| sdo_oe_n | output | 1 | Active-low enable for the serial data pad |
| dac_code | output | DATA_W | Current trial code for the DAC |
| power_on | output | 1 | Analog section powered |
| track | output | 1 | Track/hold in track |
| hold | output | 1 | Track/hold in hold; conversion running |
| mode_alt | output | 1 | Alternate mode: channel 2, or bipolar |

## Verification
On every cycle, the assertions check that track and hold never overlap, and that the output is enabled and driven low whenever the block is powered. They also check that the trial mask stays one-hot, that the shift register never moves without a cause, that shutdown follows each finished search, and that no conversion runs past its cycle budget. Only the bench scenarios can show the things that depend on a pin history: the recovered result values, the mode chosen by a short start pulse or by an abandoned readout, two's complement formatting, the release of the pad after exactly twelve clock edges, and SCLK activity being ignored.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
   typedef enum logic [1:0] {
      PH_OFF      = 2'd0,
      PH_TRACK    = 2'd1,
      PH_MODE_LOW = 2'd2,
      PH_CONV     = 2'd3
   } phase_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic level,
   output logic rise,
   output logic fall
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("pin_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain;
   logic              last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         last  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], pin};
         last  <= chain[STAGES-1];
      end
   end

   assign level = chain[STAGES-1];
   assign rise  = chain[STAGES-1] & ~last;
   assign fall  = ~chain[STAGES-1] & last;
endmodule

// File: rtl/tick_gen.sv
module tick_gen #(
   parameter int DIV = 25
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (DIV < 2) begin : g_bad
         $error("tick_gen divider must be at least 2");
      end
   endgenerate

   localparam int CW = $clog2(DIV);
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (!run)          cnt <= '0;
      else if (cnt == LAST)   cnt <= '0;
      else                    cnt <= cnt + 1'b1;
   end

   assign tick = run && (cnt == LAST);
endmodule

// File: rtl/sar_core.sv
module sar_core #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         tick,
   input  logic         cmp,
   output logic [W-1:0] trial,
   output logic         done,
   output logic [W-1:0] result
);
   generate
      if (W < 2) begin : g_bad
         $error("sar_core width must be at least 2");
      end
   endgenerate

   localparam logic [W-1:0] TOP = {1'b1, {(W-1){1'b0}}};

   logic [W-1:0] code, mask;
   logic [W-1:0] decided;

   // the bit under trial survives only on a high comparator decision
   assign decided = cmp ? code : (code & ~mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code   <= '0;
         mask   <= '0;
         done   <= 1'b0;
         result <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            code <= TOP;
            mask <= TOP;
         end else if (tick && (mask != '0)) begin
            code <= decided | (mask >> 1);
            mask <= mask >> 1;
            if (mask[0]) begin
               done   <= 1'b1;
               result <= decided;
            end
         end
      end
   end

   assign trial = code;

   AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mask)); // R12
   AST_START_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (code == TOP)); // R12
endmodule

// File: rtl/bit_shifter.sv
module bit_shifter #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_word,
   input  logic         clear,
   input  logic         shift,
   output logic         sbit,
   output logic         pending
);
   localparam int NW = $clog2(W + 1);
   localparam logic [NW-1:0] FULL = NW'(W);

   logic [W-1:0]  shreg;
   logic [NW-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         left  <= '0;
      end else if (clear) begin
         shreg <= '0;
         left  <= '0;
      end else if (load) begin
         shreg <= load_word;
         left  <= FULL;
      end else if (shift && (left != '0)) begin
         shreg <= shreg << 1;
         left  <= left - 1'b1;
      end
   end

   assign sbit    = shreg[W-1];
   assign pending = (left != '0);

   AST_SHIFT_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      !(shift || load || clear) |=> $stable(shreg)); // R8
endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl
   import conv_seq_pkg::*;
#(
   parameter int DATA_W   = 12,
   parameter int TICK_DIV = 25,
   parameter int ACQ_CYC  = 140,
   parameter int SYNC_N   = 2,
   parameter int VARIANT  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_pin,
   input  logic              sclk_pin,
   input  logic              cmp_bit,
   output logic              sdo,
   output logic              sdo_oe_n,
   output logic [DATA_W-1:0] dac_code,
   output logic              power_on,
   output logic              track,
   output logic              hold,
   output logic              mode_alt
);
   generate
      if (VARIANT != 0 && VARIANT != 1) begin : g_bad_var
         $error("VARIANT must be 0 (two-channel) or 1 (differential)");
      end
      if (ACQ_CYC < 1) begin : g_bad_acq
         $error("ACQ_CYC must be positive");
      end
   endgenerate

   localparam int AW       = $clog2(ACQ_CYC + 1);
   localparam logic [AW-1:0] ACQ_LIM = AW'(ACQ_CYC);
   localparam int CONV_MAX = DATA_W * TICK_DIV + 2;
   localparam int CCW      = $clog2(CONV_MAX + 2);
   localparam logic [DATA_W-1:0] SIGN = {1'b1, {(DATA_W-1){1'b0}}};

   phase_t phase;
   logic   st_lvl, st_rise, st_fall;
   logic   sk_lvl, sk_rise, sk_fall;
   logic   tick, sar_start, sar_done;
   logic   [DATA_W-1:0] sar_res, out_word;
   logic   [AW-1:0] acq_cnt;
   logic   alt_r, sh_pending, sh_bit, sh_clear;
   logic   [CCW-1:0] conv_cyc;

   pin_sync #(.STAGES(SYNC_N)) u_start_sync (
      .clk(clk), .rst_n(rst_n), .pin(start_pin),
      .level(st_lvl), .rise(st_rise), .fall(st_fall));

   pin_sync #(.STAGES(SYNC_N)) u_sclk_sync (
      .clk(clk), .rst_n(rst_n), .pin(sclk_pin),
      .level(sk_lvl), .rise(sk_rise), .fall(sk_fall));

   tick_gen #(.DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(phase == PH_CONV), .tick(tick));

   assign sar_start = (phase == PH_TRACK) && st_fall && (acq_cnt == ACQ_LIM);

   sar_core #(.W(DATA_W)) u_sar (
      .clk(clk), .rst_n(rst_n), .start(sar_start), .tick(tick),
      .cmp(cmp_bit), .trial(dac_code), .done(sar_done), .result(sar_res));

   // output coding chosen by variant
   generate
      if (VARIANT == 1) begin : g_diff
         assign out_word = alt_r ? (sar_res ^ SIGN) : sar_res;
      end else begin : g_two_ch
         assign out_word = sar_res;
      end
   endgenerate

   assign sh_clear = (phase == PH_OFF) && st_rise;

   bit_shifter #(.W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(sar_done), .load_word(out_word),
      .clear(sh_clear), .shift(sk_fall && (phase == PH_OFF)),
      .sbit(sh_bit), .pending(sh_pending));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_OFF;
         acq_cnt <= '0;
         alt_r   <= 1'b0;
      end else begin
         unique case (phase)
            PH_OFF: begin
               if (st_rise) begin
                  phase   <= PH_TRACK;
                  acq_cnt <= '0;
                  alt_r   <= sh_pending; // unread result forces alternate
               end
            end
            PH_TRACK: begin
               if (acq_cnt != ACQ_LIM) acq_cnt <= acq_cnt + 1'b1;
               if (st_fall) phase <= (acq_cnt == ACQ_LIM) ? PH_CONV : PH_MODE_LOW;
            end
            PH_MODE_LOW: begin
               if (st_rise) begin
                  phase   <= PH_TRACK;
                  acq_cnt <= '0;
                  alt_r   <= 1'b1;
               end
            end
            PH_CONV: begin
               if (sar_done) phase <= PH_OFF;
            end
            default: phase <= PH_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 conv_cyc <= '0;
      else if (phase != PH_CONV)  conv_cyc <= '0;
      else                        conv_cyc <= conv_cyc + 1'b1;
   end

   assign power_on = (phase != PH_OFF);
   assign track    = (phase == PH_TRACK);
   assign hold     = (phase == PH_CONV);
   assign mode_alt = alt_r;
   assign sdo_oe_n = !(power_on || sh_pending);
   assign sdo      = power_on ? 1'b0 : (sh_pending & sh_bit);

   AST_TRACK_HOLD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(track && hold)); // R2
   AST_ACTIVE_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      power_on |-> (!sdo_oe_n && !sdo)); // R5
   AST_DONE_TO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      sar_done |=> (phase == PH_OFF) && !sdo_oe_n); // R4
   AST_CONV_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> (conv_cyc <= CCW'(CONV_MAX))); // R3
endmodule

// File: tb/tb_conv_seq_ctrl.sv
module tb_conv_seq_ctrl;
   logic clk = 0, rst_n = 0, start_pin = 0, sclk_pin = 0;
   logic sdo, sdo_oe_n, power_on, track, hold, mode_alt, cmp_bit;
   logic [11:0] dac_code;
   logic [11:0] level = 0;
   int n_chk = 0, n_fail = 0;
   logic [11:0] expq[$];

   always #5 clk = ~clk;

   conv_seq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .start_pin(start_pin), .sclk_pin(sclk_pin),
      .cmp_bit(cmp_bit), .sdo(sdo), .sdo_oe_n(sdo_oe_n), .dac_code(dac_code),
      .power_on(power_on), .track(track), .hold(hold), .mode_alt(mode_alt));

   // abstract comparator: input at or above trial code
   assign cmp_bit = (level >= dac_code);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wcyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // driver: runs a conversion and pushes the expected word
   task automatic convert(input logic [11:0] lvl, input bit alt, input bit check_steps);
      int hc;
      level = lvl;
      start_pin = 1; wcyc(8);
      if (check_steps) begin
         chk("R2 power_on", power_on, 1); chk("R2 track", track, 1);
         chk("R5 sdo low", sdo, 0); chk("R5 oe low", sdo_oe_n, 0);
      end
      if (alt) begin
         start_pin = 0; wcyc(8);
         start_pin = 1; wcyc(8);
      end
      wcyc(150);
      start_pin = 0; wcyc(4);
      if (check_steps) begin
         chk("R2 hold", hold, 1); chk("R2 track off", track, 0);
         chk("R12 first trial", dac_code, 12'h800);
      end
      hc = 4;
      while (hold && hc < 1000) begin wcyc(1); hc++; end
      if (check_steps) begin
         chk("R3 hold min", (hc >= 300) ? 1 : 0, 1);
         chk("R3 hold max", (hc <= 305) ? 1 : 0, 1);
      end
      expq.push_back(alt ? (lvl ^ 12'h800) : lvl);
   endtask

   // monitor: shifts out nbits and compares against the scoreboard
   task automatic readout(input string req, input int nbits);
      logic [11:0] got, exp;
      got = 0;
      for (int i = 0; i < nbits; i++) begin
         got = {got[10:0], sdo};
         sclk_pin = 1; wcyc(6);
         sclk_pin = 0; wcyc(6);
      end
      exp = expq.pop_front();
      if (nbits == 12) chk(req, got, exp);
   endtask

   initial begin
      wcyc(3); rst_n = 1; wcyc(2);
      chk("R1 power_on", power_on, 0); chk("R1 track", track, 0);
      chk("R1 hold", hold, 0); chk("R1 oe_n", sdo_oe_n, 1);

      // R8: clock activity in shutdown with nothing pending
      sclk_pin = 1; wcyc(6); sclk_pin = 0; wcyc(6);
      chk("R8 idle sclk oe_n", sdo_oe_n, 1);

      convert(12'hA5C, 0, 1);
      chk("R4 power off", power_on, 0); chk("R4 oe on", sdo_oe_n, 0);
      chk("R4 msb shown", sdo, 1);
      chk("R9 default mode", mode_alt, 0);
      readout("R6 word A5C", 12);
      chk("R7 released", sdo_oe_n, 1);

      // R8: sclk toggling during conversion ignored
      level = 12'h3F1; start_pin = 1; wcyc(160); start_pin = 0;
      for (int i = 0; i < 10; i++) begin sclk_pin = 1; wcyc(6); sclk_pin = 0; wcyc(6); end
      while (hold) wcyc(1);
      expq.push_back(12'h3F1);
      readout("R8 word after sclk in conversion", 12);

      convert(12'h000, 0, 0); readout("R6 word zero", 12);
      convert(12'hFFF, 0, 0); readout("R6 word full", 12);

      convert(12'h123, 1, 0);
      chk("R9 alt mode", mode_alt, 1);
      readout("R10 twos complement 123", 12);
      convert(12'h900, 1, 0); readout("R10 twos complement 900", 12);
      convert(12'h456, 0, 0);
      chk("R10 unipolar mode", mode_alt, 0);
      readout("R10 straight binary 456", 12);

      // R11: abandon readout after 5 bits
      convert(12'h777, 0, 0);
      readout("R11 partial", 5);
      convert(12'h2B4, 0, 0);
      chk("R11 forced alt", mode_alt, 1);
      void'(expq.pop_back());
      expq.push_back(12'h2B4 ^ 12'h800);
      readout("R11 forced alt word", 12);
      chk("R7 released again", sdo_oe_n, 1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule